// File: doc/BRIEF.md
# Sequencing Timer Bank

This block is a bank of independent delay timers that serves a power-sequencing state machine. A single prescaler divides the master clock (8 MHz in the intended system) by a fixed ratio, 32 by default. It produces a one-cycle tick strobe at 250 kHz, and every timer counts that strobe. The sequencer pulses a timer's start line and gives it an interval code. It then waits for that timer's done flag, which rises once the coded number of ticks has passed.

The interval code is a small floating-point value. The low field is a mantissa with an implied leading one, and the high field is a binary exponent. With the default widths the 128 codes span 8 ticks (32 µs) up to 491520 ticks (about 1.97 s). The prescaler also produces a square wave at the tick rate. That wave can be driven onto an output as a slow logic clock, under an enable input.

Top module: `seq_timer_bank`

## Requirements
- R1: `tick_o` is high for exactly one master clock in every DIV clocks. Its first pulse appears in the DIV-th cycle after reset is released.
- R2: A code splits as {exponent, mantissa}, with the mantissa in the low MANT_W bits. The interval is (2^MANT_W + mantissa) << exponent ticks. With defaults, code 0 gives 8 ticks (32 µs) and code 127 gives 491520 ticks.
- R3: Done rises on the clock edge that samples the N-th tick strobe after the start cycle. A strobe coinciding with the start cycle is not counted.
- R4: A start pulse clears that timer's done on the next edge and restarts the count from the full interval, even while the timer is already running.
- R5: Once high, done stays high until the next start of that timer or a reset.
- R6: Each timer's start, code and done act independently of the other timers.
- R7: The code is captured only in the start cycle. Changing it while the timer runs does not change when done rises.
- R8: With `route_en_i` high, `logic_clk_o` is low for the first DIV/2 clocks of each prescaler period and high for the rest. With `route_en_i` low, it is held low.
- R9: While `rst_ni` is low and after it is released, all done flags, `tick_o` and `logic_clk_o` are low. A timer that has not been started never raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | N_TMR | per-timer start pulse |
| code_i | input | N_TMR*(EXP_W+MANT_W) | per-timer interval codes, timer k in slice k |
| route_en_i | input | 1 | enables the logic clock output |
| tick_o | output | 1 | prescaled tick strobe |
| logic_clk_o | output | 1 | prescaled square wave, gated by route_en_i |
| done_o | output | N_TMR | per-timer interval elapsed flag |

## Verification
The timers are run with the smallest code and the largest code, so that each result is a count of ticks. This separates an off-by-one in the counter from an error in the exponent shift. A mid-range code with a non-zero mantissa and exponent shows whether the two fields are swapped. A restart during a run checks that the reload is complete, and a code change after the start checks that the code is captured only once. Two timers started together with different codes expose any coupling between channels. A reset during a run and a stretch with the route enable low check the reset state and the clock gating.

// File: rtl/seq_timer_pkg.sv
package seq_timer_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tmr_state_e;

  function automatic int unsigned cnt_width(int unsigned exp_w, int unsigned mant_w);
    return mant_w + 1 + (1 << exp_w) - 1;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic route_en_i,
  output logic tick_o,
  output logic logic_clk_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] HALF = PW'(DIV / 2);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o      = (pre_q == LAST);
  assign logic_clk_o = route_en_i & (pre_q >= HALF);
endmodule

// File: rtl/interval_decode.sv
module interval_decode #(
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned MANT_W = 3,
  parameter int unsigned CNT_W  = 19
) (
  input  logic [EXP_W+MANT_W-1:0] code_i,
  output logic [CNT_W-1:0]        ticks_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [MANT_W:0]   mant_full;

  assign exp_w     = code_i[EXP_W+MANT_W-1:MANT_W];
  assign mant_full = {1'b1, code_i[MANT_W-1:0]};
  assign ticks_o   = CNT_W'(mant_full) << exp_w;
endmodule

// File: rtl/seq_timer.sv
module seq_timer
  import seq_timer_pkg::*;
#(
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned MANT_W = 3,
  parameter int unsigned CNT_W  = 19
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    start_i,
  input  logic [EXP_W+MANT_W-1:0] code_i,
  output logic                    done_o
);
  logic [CNT_W-1:0] load_w;
  logic [CNT_W-1:0] cnt_q;
  tmr_state_e       st_q;
  logic             done_q;

  interval_decode #(.EXP_W(EXP_W), .MANT_W(MANT_W), .CNT_W(CNT_W)) i_dec (
    .code_i (code_i),
    .ticks_o(load_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_w;
      st_q   <= ST_RUN;
      done_q <= 1'b0;
    end else if (st_q == ST_RUN && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q  <= '0;
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/seq_timer_bank.sv
module seq_timer_bank
  import seq_timer_pkg::*;
#(
  parameter int unsigned N_TMR  = 4,
  parameter int unsigned DIV    = 32,
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned MANT_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_TMR-1:0]              start_i,
  input  logic [N_TMR*(EXP_W+MANT_W)-1:0] code_i,
  input  logic                          route_en_i,
  output logic                          tick_o,
  output logic                          logic_clk_o,
  output logic [N_TMR-1:0]              done_o
);
  localparam int unsigned CODE_W = EXP_W + MANT_W;
  localparam int unsigned CNT_W  = cnt_width(EXP_W, MANT_W);

  logic tick_w;

  tick_prescaler #(.DIV(DIV)) i_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .route_en_i (route_en_i),
    .tick_o     (tick_w),
    .logic_clk_o(logic_clk_o)
  );

  assign tick_o = tick_w;

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    seq_timer #(.EXP_W(EXP_W), .MANT_W(MANT_W), .CNT_W(CNT_W)) i_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_w),
      .start_i(start_i[k]),
      .code_i (code_i[k*CODE_W +: CODE_W]),
      .done_o (done_o[k])
    );
  end
endmodule

// File: rtl/seq_timer_bank_chk.sv
module seq_timer_bank_chk #(
  parameter int unsigned N_TMR = 4,
  parameter int unsigned DIV   = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_TMR-1:0] start_i,
  input logic             route_en_i,
  input logic             tick_o,
  input logic             logic_clk_o,
  input logic [N_TMR-1:0] done_o
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= 0;
    else if (tick_o) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  a_r1_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == DIV - 1));

  a_r8_route_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_en_i |-> !logic_clk_o);

  for (genvar k = 0; k < N_TMR; k++) begin : g_chk
    a_r4_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[k] |=> !done_o[k]);
    a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o[k] && !start_i[k]) |=> done_o[k]);
    a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o[k]) |-> $past(tick_o));
  end
endmodule

bind seq_timer_bank seq_timer_bank_chk #(.N_TMR(N_TMR), .DIV(DIV)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .route_en_i (route_en_i),
  .tick_o     (tick_o),
  .logic_clk_o(logic_clk_o),
  .done_o     (done_o)
);

// File: tb/test_seq_timer_bank.sv
module test_seq_timer_bank;
  localparam int N = 4;
  localparam int DIV = 4;
  localparam int EW = 3;
  localparam int MW = 3;
  localparam int CW = EW + MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] start = '0;
  logic [CW-1:0] code [N];
  logic [N*CW-1:0] code_flat;
  logic route_en = 1'b0;
  logic tick, lclk;
  logic [N-1:0] done;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  for (genvar k = 0; k < N; k++) begin : g_flat
    assign code_flat[k*CW +: CW] = code[k];
  end

  seq_timer_bank #(.N_TMR(N), .DIV(DIV), .EXP_W(EW), .MANT_W(MW)) i_seq_timer_bank (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code_flat),
    .route_en_i(route_en), .tick_o(tick), .logic_clk_o(lclk), .done_o(done)
  );

  function automatic int want_ticks(logic [CW-1:0] c);
    return ((1 << MW) + int'(c[MW-1:0])) << int'(c[CW-1:MW]);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference model, stepped on every edge, compared 2 ns later
  int m_pre = 0;
  int m_rem [N];
  bit m_run [N];
  bit m_done [N];

  always @(posedge clk) begin
    bit t;
    cyc++;
    if (!rst_n) begin
      m_pre = 0;
      for (int k = 0; k < N; k++) begin m_rem[k] = 0; m_run[k] = 0; m_done[k] = 0; end
    end else begin
      t = (m_pre == DIV - 1);
      for (int k = 0; k < N; k++) begin
        if (start[k]) begin
          m_rem[k] = want_ticks(code[k]); m_run[k] = 1; m_done[k] = 0;
        end else if (m_run[k] && t) begin
          m_rem[k]--;
          if (m_rem[k] == 0) begin m_run[k] = 0; m_done[k] = 1; end
        end
      end
      m_pre = (m_pre + 1) % DIV;
    end
    #2;
    if (rst_n) begin
      check("R1 tick_o", int'(tick), int'(m_pre == DIV - 1));
      check("R8 logic_clk_o", int'(lclk), int'(route_en && m_pre >= DIV / 2));
      for (int k = 0; k < N; k++) check("R3 done_o", int'(done[k]), int'(m_done[k]));
    end
  end

  // start timer k, change code afterwards, count ticks until done
  task automatic measure(int k, logic [CW-1:0] c, logic [CW-1:0] c_after, output int n);
    @(negedge clk);
    code[k] = c; start[k] = 1'b1;
    @(posedge clk); #3;
    start[k] = 1'b0; code[k] = c_after;
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      if (done[k]) break;
      if (tick) n++;
      @(posedge clk); #3;
    end
  endtask

  initial begin
    int n;
    for (int k = 0; k < N; k++) code[k] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done in reset", int'(done), 0);
    check("R9 tick in reset", int'(tick), 0);
    check("R9 lclk in reset", int'(lclk), 0);
    rst_n = 1'b1;
    route_en = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 idle timers stay low", int'(done), 0);

    measure(0, 6'd0, 6'd0, n);        check("R2 min interval", n, 8);
    measure(1, 6'd63, 6'd63, n);      check("R2 max interval", n, 1920);
    measure(2, 6'o25, 6'o25, n);      check("R2 exp2 mant5", n, 52);

    repeat (50) @(negedge clk);
    check("R5 done held", int'(done[2:0]), 3'b111);

    // R4 retrigger mid-run
    @(negedge clk); code[0] = 6'o10; start[0] = 1'b1;
    @(negedge clk); start[0] = 1'b0;
    repeat (20) @(negedge clk);
    measure(0, 6'd0, 6'd0, n);        check("R4 restart reload", n, 8);

    // R7 code change after start is ignored
    measure(3, 6'd0, 6'd63, n);       check("R7 code captured", n, 8);

    // R6 two timers started together
    @(negedge clk); code[1] = 6'o11; code[2] = 6'd0; start[2:1] = 2'b11;
    @(negedge clk); start[2:1] = 2'b00;
    repeat (8 * DIV + 2) @(negedge clk);
    check("R6 short timer done", int'(done[2]), 1);
    check("R6 long timer still running", int'(done[1]), 0);
    repeat (10 * DIV + 2) @(negedge clk);
    check("R6 long timer done", int'(done[1]), 1);

    // R8 gated output
    route_en = 1'b0;
    n = 0;
    for (int i = 0; i < 4 * DIV; i++) begin @(negedge clk); if (lclk) n++; end
    check("R8 gated low", n, 0);
    route_en = 1'b1;

    // R9 reset during run
    @(negedge clk); code[3] = 6'd0; start[3] = 1'b1;
    @(negedge clk); start[3] = 1'b0; rst_n = 1'b0;
    @(negedge clk); check("R9 reset clears", int'(done), 0);
    rst_n = 1'b1;
    repeat (20 * DIV) @(negedge clk);
    check("R9 no done after reset", int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule